// File: doc/BRIEF.md
# Pipeline Hazard Detection and Operand Forwarding Unit

This block sits beside the execute stage of an in-order, five-stage integer pipeline. It compares the source register numbers of the instruction now in execute against the destination registers of the two older instructions that have not yet retired into the register file. From that comparison it picks, for each ALU operand, where the operand value must come from. The choices are the register-file value read in decode, the result held in the execute/memory pipeline register, or the value that the write-back stage is about to commit.

The block also catches the one dependence that forwarding cannot hide. A load sitting in execute whose destination is read by the instruction now in decode has no data until the end of the memory stage. In that case the block holds the program counter and the fetch/decode register for one cycle. It also turns the instruction entering execute into a no-op bubble. The unit is purely combinational, so every result applies in the same cycle as the stage contents that caused it. The surrounding pipeline registers its outputs at the next edge.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes a register (`mem_wr_en`=1), its destination is nonzero, and that destination equals an execute-stage source, that operand's select is 2'b10.
- R2: When the write-back-stage instruction writes a nonzero destination equal to an execute-stage source, and R1 does not apply to that operand, the select is 2'b01. This holds whether the write-back value came from a load or from the ALU.
- R3: When both the memory-stage and the write-back-stage destinations match the same source, the select is 2'b10, because the younger result wins.
- R4: Register 0 is never forwarded. A producer with its write enable clear is never forwarded, even when its destination number matches.
- R5: An operand with no matching producer gets select 2'b00, the register-file value.
- R6: When `ex_load`=1, `ex_dst` is nonzero, and `ex_dst` equals `id_src_a` or `id_src_b`, then `pc_write`=0, `ifid_write`=0 and `ex_bubble`=1 in that cycle.
- R7: In every other case `pc_write`=1, `ifid_write`=1 and `ex_bubble`=0. This includes a decode-stage source that depends on a non-load instruction in execute, or on the memory or write-back stage.
- R8: The two operand selects are decided independently. Operand A may forward from one stage while operand B forwards from another.
- R9: The select value 2'b11 is never produced.
- R10: The outputs depend only on the current inputs. They hold no state and follow a change of the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_ADDR_W | First source register of the instruction in decode |
| id_src_b | input | REG_ADDR_W | Second source register of the instruction in decode |
| ex_src_a | input | REG_ADDR_W | First source register of the instruction in execute |
| ex_src_b | input | REG_ADDR_W | Second source register of the instruction in execute |
| ex_dst | input | REG_ADDR_W | Destination register of the instruction in execute |
| ex_load | input | 1 | Instruction in execute reads data memory (load) |
| mem_dst | input | REG_ADDR_W | Destination register of the instruction in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes the register file |
| wb_dst | input | REG_ADDR_W | Destination register of the instruction in write-back |
| wb_wr_en | input | 1 | Write-back instruction writes the register file |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 10 memory-stage result, 01 write-back value |
| fwd_sel_b | output | 2 | Operand B source, same encoding as fwd_sel_a |
| pc_write | output | 1 | Program counter may advance (0 while stalling) |
| ifid_write | output | 1 | Fetch/decode register may load (0 while stalling) |
| ex_bubble | output | 1 | Replace the instruction entering execute with a no-op |

## Verification
Every result of this unit is due in the same cycle as the pipeline-stage contents that cause it, with zero register delay. A stall or forwarding select that appeared one cycle late would be a defect. The bench therefore applies each new set of stage fields just after a rising edge and compares all five outputs at the following falling edge, inside that same cycle. It uses a behavioural model that scans the older producers from youngest to oldest. A run of directed stage patterns covers the priority, zero-register, write-enable and load-distance cases. It is followed by a long run of random patterns drawn from a small register range, so that matches are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    localparam int NUM_SRC = 2;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  mem_wr_en,
    input  logic [REG_ADDR_W-1:0] wb_dst,
    input  logic                  wb_wr_en,
    output logic [1:0]            sel
);

    typedef struct packed {
        logic     mem_hit;
        logic     wb_hit;
        fwd_sel_e choice;
    } pick_t;

    pick_t pick_d;

    always_comb begin
        pick_d         = '0;
        pick_d.mem_hit = mem_wr_en && (mem_dst != '0) && (mem_dst == src);
        pick_d.wb_hit  = wb_wr_en  && (wb_dst  != '0) && (wb_dst  == src);
        // the younger producer wins (R3)
        if (pick_d.mem_hit) begin
            pick_d.choice = FWD_MEM;
        end else if (pick_d.wb_hit) begin
            pick_d.choice = FWD_WB;
        end else begin
            pick_d.choice = FWD_RF;
        end
    end

    assign sel = pick_d.choice;

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] id_src_a,
    input  logic [REG_ADDR_W-1:0] id_src_b,
    input  logic [REG_ADDR_W-1:0] ex_dst,
    input  logic                  ex_load,
    output logic                  stall
);

    typedef struct packed {
        logic dst_live;
        logic hit_a;
        logic hit_b;
        logic stall;
    } lu_t;

    lu_t lu_d;

    always_comb begin
        lu_d          = '0;
        lu_d.dst_live = ex_load && (ex_dst != '0);
        lu_d.hit_a    = (ex_dst == id_src_a);
        lu_d.hit_b    = (ex_dst == id_src_b);
        lu_d.stall    = lu_d.dst_live && (lu_d.hit_a || lu_d.hit_b);
    end

    assign stall = lu_d.stall;

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] id_src_a,
    input  logic [REG_ADDR_W-1:0] id_src_b,
    input  logic [REG_ADDR_W-1:0] ex_src_a,
    input  logic [REG_ADDR_W-1:0] ex_src_b,
    input  logic [REG_ADDR_W-1:0] ex_dst,
    input  logic                  ex_load,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  mem_wr_en,
    input  logic [REG_ADDR_W-1:0] wb_dst,
    input  logic                  wb_wr_en,
    output logic [1:0]            fwd_sel_a,
    output logic [1:0]            fwd_sel_b,
    output logic                  pc_write,
    output logic                  ifid_write,
    output logic                  ex_bubble
);

    logic [NUM_SRC-1:0][REG_ADDR_W-1:0] ex_src_vec;
    logic [NUM_SRC-1:0][1:0]            sel_vec;
    logic                               lu_stall;

    assign ex_src_vec = {ex_src_b, ex_src_a};

    // one forwarding picker per execute operand (R8)
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        hz_fwd_pick #(
            .REG_ADDR_W (REG_ADDR_W)
        ) u_pick (
            .src       (ex_src_vec[gi]),
            .mem_dst   (mem_dst),
            .mem_wr_en (mem_wr_en),
            .wb_dst    (wb_dst),
            .wb_wr_en  (wb_wr_en),
            .sel       (sel_vec[gi])
        );
    end

    hz_load_use #(
        .REG_ADDR_W (REG_ADDR_W)
    ) u_lu (
        .id_src_a (id_src_a),
        .id_src_b (id_src_b),
        .ex_dst   (ex_dst),
        .ex_load  (ex_load),
        .stall    (lu_stall)
    );

    typedef struct packed {
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic       pc_we;
        logic       ifid_we;
        logic       bubble;
    } out_t;

    out_t out_d;

    always_comb begin
        out_d         = '0;
        out_d.sel_a   = sel_vec[0];
        out_d.sel_b   = sel_vec[1];
        out_d.pc_we   = !lu_stall;
        out_d.ifid_we = !lu_stall;
        out_d.bubble  = lu_stall;
    end

    assign fwd_sel_a  = out_d.sel_a;
    assign fwd_sel_b  = out_d.sel_b;
    assign pc_write   = out_d.pc_we;
    assign ifid_write = out_d.ifid_we;
    assign ex_bubble  = out_d.bubble;

endmodule

// File: rtl/hz_chk.sv
module hz_chk #(
    parameter int REG_ADDR_W = 5
) (
    input logic [REG_ADDR_W-1:0] id_src_a,
    input logic [REG_ADDR_W-1:0] id_src_b,
    input logic [REG_ADDR_W-1:0] ex_src_a,
    input logic [REG_ADDR_W-1:0] ex_src_b,
    input logic [REG_ADDR_W-1:0] ex_dst,
    input logic                  ex_load,
    input logic [REG_ADDR_W-1:0] mem_dst,
    input logic                  mem_wr_en,
    input logic [REG_ADDR_W-1:0] wb_dst,
    input logic                  wb_wr_en,
    input logic [1:0]            fwd_sel_a,
    input logic [1:0]            fwd_sel_b,
    input logic                  pc_write,
    input logic                  ifid_write,
    input logic                  ex_bubble
);

    always_comb begin
        p_sel_legal_r9: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
            else $error("illegal forwarding select");
        p_mem_fwd_live_r4: assert (fwd_sel_a != 2'b10 || (mem_wr_en && mem_dst != '0))
            else $error("forwarded from a dead memory-stage producer");
        p_wb_fwd_live_r4: assert (fwd_sel_b != 2'b01 || (wb_wr_en && wb_dst != '0))
            else $error("forwarded from a dead write-back producer");
        p_priority_r3: assert (fwd_sel_a != 2'b01 ||
                               !(mem_wr_en && mem_dst != '0 && mem_dst == ex_src_a))
            else $error("older producer chosen over younger one");
        p_bubble_needs_load_r6: assert (!ex_bubble || (ex_load && ex_dst != '0))
            else $error("bubble without a live load in execute");
        p_freeze_consistent_r7: assert (pc_write == ifid_write && pc_write == !ex_bubble)
            else $error("stall outputs disagree");
    end

endmodule

bind hazard_fwd_unit hz_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .ex_src_a   (ex_src_a),
    .ex_src_b   (ex_src_b),
    .ex_dst     (ex_dst),
    .ex_load    (ex_load),
    .mem_dst    (mem_dst),
    .mem_wr_en  (mem_wr_en),
    .wb_dst     (wb_dst),
    .wb_wr_en   (wb_wr_en),
    .fwd_sel_a  (fwd_sel_a),
    .fwd_sel_b  (fwd_sel_b),
    .pc_write   (pc_write),
    .ifid_write (ifid_write),
    .ex_bubble  (ex_bubble)
);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RW         = 5;

    logic          clk = 1'b0;
    logic [RW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
    logic          ex_load, mem_wr_en, wb_wr_en;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          pc_write, ifid_write, ex_bubble;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_fwd_unit #(.REG_ADDR_W(RW)) u_dut (
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .ex_src_a   (ex_src_a),
        .ex_src_b   (ex_src_b),
        .ex_dst     (ex_dst),
        .ex_load    (ex_load),
        .mem_dst    (mem_dst),
        .mem_wr_en  (mem_wr_en),
        .wb_dst     (wb_dst),
        .wb_wr_en   (wb_wr_en),
        .fwd_sel_a  (fwd_sel_a),
        .fwd_sel_b  (fwd_sel_b),
        .pc_write   (pc_write),
        .ifid_write (ifid_write),
        .ex_bubble  (ex_bubble)
    );

    // Reference: scan the in-flight producers youngest first; first live match wins.
    function automatic int ref_sel(input logic [RW-1:0] src);
        int pdst[$];
        int pen[$];
        int pcode[$];
        pdst  = '{int'(mem_dst), int'(wb_dst)};
        pen   = '{int'(mem_wr_en), int'(wb_wr_en)};
        pcode = '{2, 1};
        foreach (pdst[k]) begin
            if (pen[k] == 1 && pdst[k] != 0 && pdst[k] == int'(src)) return pcode[k];
        end
        return 0;
    endfunction

    function automatic int ref_stall();
        if (ex_load !== 1'b1 || ex_dst == 0) return 0;
        if (ex_dst == id_src_a || ex_dst == id_src_b) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(input int e);
        if (e == 2) return "R1";
        if (e == 1) return "R2";
        return "R5";
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare all outputs against the model; sampled at the falling edge
    task automatic check_all(input string req);
        int ea, eb, es;
        ea = ref_sel(ex_src_a);
        eb = ref_sel(ex_src_b);
        es = ref_stall();
        chk(req == "" ? sel_tag(ea) : req, "fwd_sel_a", int'(fwd_sel_a), ea);
        chk(req == "" ? sel_tag(eb) : req, "fwd_sel_b", int'(fwd_sel_b), eb);
        chk(req == "" ? (es == 1 ? "R6" : "R7") : req, "stall_group",
            int'({pc_write, ifid_write, ex_bubble}), es == 1 ? 1 : 6);
    endtask

    task automatic apply(input logic [RW-1:0] ia, ib, xa, xb, xd, input logic xl,
                         input logic [RW-1:0] md, input logic me,
                         input logic [RW-1:0] wd, input logic we);
        @(posedge clk);
        #1;
        id_src_a = ia; id_src_b = ib; ex_src_a = xa; ex_src_b = xb;
        ex_dst = xd; ex_load = xl; mem_dst = md; mem_wr_en = me;
        wb_dst = wd; wb_wr_en = we;
        @(negedge clk);
    endtask

    initial begin
        id_src_a = '0; id_src_b = '0; ex_src_a = '0; ex_src_b = '0; ex_dst = '0;
        ex_load = 1'b0; mem_dst = '0; mem_wr_en = 1'b0; wb_dst = '0; wb_wr_en = 1'b0;

        // idle state: nothing forwarded, pipeline free to advance (R5, R7)
        apply(0,0,0,0,0,0, 0,0, 0,0);
        chk("R5", "idle sel_a", int'(fwd_sel_a), 0);
        chk("R7", "idle pc_write", int'(pc_write), 1);
        // R1: memory-stage producer
        apply(0,0,3,9,0,0, 3,1, 0,0);
        chk("R1", "mem fwd a", int'(fwd_sel_a), 2);
        chk("R5", "unrelated b", int'(fwd_sel_b), 0);
        // R2: write-back producer
        apply(0,0,8,4,0,0, 0,0, 4,1);
        chk("R2", "wb fwd b", int'(fwd_sel_b), 1);
        // R3: both match, younger wins
        apply(0,0,5,5,0,0, 5,1, 5,1);
        chk("R3", "priority a", int'(fwd_sel_a), 2);
        chk("R3", "priority b", int'(fwd_sel_b), 2);
        // R4: register 0 and disabled writers
        apply(0,0,0,0,0,0, 0,1, 0,1);
        chk("R4", "r0 not fwd a", int'(fwd_sel_a), 0);
        apply(0,0,6,6,0,0, 6,0, 6,0);
        chk("R4", "wr_en clear a", int'(fwd_sel_a), 0);
        apply(0,0,6,2,0,0, 6,0, 6,1);
        chk("R4", "mem disabled falls to wb", int'(fwd_sel_a), 1);
        // R6: load-use stall via source b
        apply(1,7,0,0,7,1, 0,0, 0,0);
        chk("R6", "stall pc_write", int'(pc_write), 0);
        chk("R6", "stall ifid_write", int'(ifid_write), 0);
        chk("R6", "stall bubble", int'(ex_bubble), 1);
        // R6 via source a, load to r0 does not stall
        apply(9,2,0,0,9,1, 0,0, 0,0);
        chk("R6", "stall via a", int'(ex_bubble), 1);
        apply(0,0,0,0,0,1, 0,0, 0,0);
        chk("R6", "load to r0 no stall", int'(ex_bubble), 0);
        // R7: non-load in execute and older producers never stall
        apply(7,7,0,0,7,0, 0,0, 0,0);
        chk("R7", "alu dep no stall", int'(pc_write), 1);
        apply(4,5,0,0,1,1, 4,1, 5,1);
        chk("R7", "mem/wb dep no stall", int'(ex_bubble), 0);
        // R8: independent operands
        apply(0,0,10,11,0,0, 10,1, 11,1);
        chk("R8", "indep a", int'(fwd_sel_a), 2);
        chk("R8", "indep b", int'(fwd_sel_b), 1);
        // R10: output follows an input change inside the same cycle
        @(posedge clk); #1;
        mem_wr_en = 1'b0;
        #1;
        chk("R10", "same-cycle follow a", int'(fwd_sel_a), 0);
        ex_load = 1'b1; ex_dst = 11; id_src_a = 11;
        #1;
        chk("R10", "same-cycle stall", int'(ex_bubble), 1);
        @(negedge clk);

        // random traffic over a small register range, compared every clock
        for (int i = 0; i < 800; i++) begin
            apply(RW'($urandom_range(0,3)), RW'($urandom_range(0,3)),
                  RW'($urandom_range(0,3)), RW'($urandom_range(0,3)),
                  RW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                  RW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                  RW'($urandom_range(0,3)), 1'($urandom_range(0,1)));
            check_all("");
            chk("R9", "no 11 select", int'(fwd_sel_a == 2'b11 || fwd_sel_b == 2'b11), 0);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule